// File: doc/BRIEF.md
# Iterative AES Decryption Round Engine

This block recovers one 128-bit plaintext block from an AES ciphertext block, executing one inverse round per clock cycle. It serves all three standard key lengths (10, 12 or 14 rounds) and works directly from the ordinary forward key schedule. It publishes a round-key index on a port, and an external key store answers combinationally with that 128-bit round key in the same cycle. The index counts down from the last round key to round key 0.

A start pulse captures the ciphertext and the key-length code while the engine is idle. In the same cycle the engine adds the highest-numbered round key, so the index port already shows that round number while the engine is idle. Each following cycle performs one inverse round. The final round leaves out the column mixing and adds round key 0. A single-cycle done pulse then marks the recovered plaintext, which stays on its output until the next block completes.

Top module: `aes_inv_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done_o` and `busy_o` are 0 and `pt_o` is all zeros.
- R2: When idle, `rk_idx_o` shows the round count chosen by `klen_i`. Code 0 selects 10, code 1 selects 12, and codes 2 and 3 both select 14.
- R3: A start pulse sampled while idle XORs `ct_i` with the round key returned for index Nr. On each later cycle `rk_idx_o` shows Nr-1, Nr-2, and so on down to 0, one step per clock.
- R4: `busy_o` is high for exactly Nr cycles after the start edge. `done_o` is high for exactly one cycle, the first cycle after those Nr cycles.
- R5: Every inverse round except the last applies, in this order, inverse row rotation (row r rotated right by r bytes), inverse byte substitution, round-key XOR, and inverse column mixing with coefficients 0e, 0b, 0d, 09. The last round leaves out the column mixing.
- R6: For every key length, decrypting a ciphertext made by the standard forward cipher under the same round keys returns the original plaintext exactly.
- R7: Blocks and round keys are read column by column. State byte 0 (row 0, column 0) is bits 127:120, byte 1 (row 1, column 0) is bits 119:112, and byte 15 is bits 7:0.
- R8: `pt_o` changes only in the cycle in which `done_o` is high, and holds its value at all other times.
- R9: A start pulse that arrives while busy has no effect. The block in progress finishes on time with its original result, and the new `ct_i` is never used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin decrypting `ct_i` (honoured only when idle) |
| klen_i | input | 2 | Key-length code: 0 gives 10 rounds, 1 gives 12, 2 or 3 gives 14 |
| ct_i | input | 128 | Ciphertext block, sampled with the start pulse |
| rk_idx_o | output | 4 | Index of the round key needed this cycle |
| rk_i | input | 128 | Round key for `rk_idx_o`, valid in the same cycle |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the plaintext is ready |
| pt_o | output | 128 | Recovered plaintext, held between completions |

## Verification
A published known-answer vector for each key length pins down the byte layout and the overall round structure. A wrong row rotation, the wrong key order, or a misplaced skip of the column mixing each breaks these outputs. For every key-length code, including the redundant code 3, the bench decrypts an all-zeros block, an all-ones block and random blocks under random keys, and compares each result against its own forward encryption. A sweep of all 128 single-bit plaintexts under one key exposes any byte or bit that is wired to the wrong position. Start pulses with a different ciphertext are injected during some runs, which separates an engine that ignores them from one that restarts or reloads.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    localparam int NB        = 4;
    localparam int BLK_BYTES = 4 * NB;
    localparam int BLK_W     = 8 * BLK_BYTES;
    localparam int RIDX_W    = 4;

    typedef logic [7:0] gbyte_t;
    // element 0 sits in the most significant byte (column-major state)
    typedef logic [0:BLK_BYTES-1][7:0] aes_blk_t;
    typedef logic [0:3][7:0] aes_col_t;

    typedef enum logic [1:0] {
        KLEN_128  = 2'd0,
        KLEN_192  = 2'd1,
        KLEN_256  = 2'd2,
        KLEN_256B = 2'd3
    } klen_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic              load;
        logic              run;
        logic              last;
        logic [RIDX_W-1:0] idx;
    } seq_t;

    function automatic logic [RIDX_W-1:0] nr_of(klen_e k);
        case (k)
            KLEN_128: return RIDX_W'(10);
            KLEN_192: return RIDX_W'(12);
            default:  return RIDX_W'(14);
        endcase
    endfunction

    function automatic gbyte_t gf_dbl(gbyte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic gbyte_t gf_mul(gbyte_t a, gbyte_t b);
        gbyte_t acc = 8'h00;
        gbyte_t p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_dbl(p);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (maps 0 to 0)
    function automatic gbyte_t gf_inv(gbyte_t x);
        gbyte_t x3, x7, x15, x31, x63, x127;
        x3   = gf_mul(gf_mul(x, x), x);
        x7   = gf_mul(gf_mul(x3, x3), x);
        x15  = gf_mul(gf_mul(x7, x7), x);
        x31  = gf_mul(gf_mul(x15, x15), x);
        x63  = gf_mul(gf_mul(x31, x31), x);
        x127 = gf_mul(gf_mul(x63, x63), x);
        return gf_mul(x127, x127);
    endfunction

    function automatic gbyte_t rotl8(gbyte_t v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic gbyte_t inv_affine(gbyte_t s);
        return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
    endfunction

    function automatic gbyte_t inv_mix_coef(int k);
        case (k)
            0:       return 8'h0e;
            1:       return 8'h0b;
            2:       return 8'h0d;
            default: return 8'h09;
        endcase
    endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
    import aes_inv_pkg::*;
(
    input  gbyte_t din,
    output gbyte_t dout
);
    assign dout = gf_inv(inv_affine(din));
endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
    import aes_inv_pkg::*;
(
    input  aes_col_t col_i,
    output aes_col_t col_o
);
    for (genvar r = 0; r < 4; r++) begin : g_row
        gbyte_t acc;
        always_comb begin
            acc = 8'h00;
            for (int j = 0; j < 4; j++) begin
                acc = acc ^ gf_mul(inv_mix_coef((j - r + 4) % 4), col_i[j]);
            end
        end
        assign col_o[r] = acc;
    end
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  aes_blk_t blk_i,
    input  aes_blk_t rkey_i,
    input  logic     skip_mix_i,
    output aes_blk_t blk_o
);
    aes_blk_t shifted, subbed, keyed, mixed;

    // inverse row rotation: row r moves right by r columns
    for (genvar c = 0; c < NB; c++) begin : g_col_shift
        for (genvar r = 0; r < 4; r++) begin : g_row_shift
            assign shifted[c*4 + r] = blk_i[((c - r + NB) % NB)*4 + r];
        end
    end

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_sub
        aes_inv_sbox u_sbox (
            .din  (shifted[i]),
            .dout (subbed[i])
        );
    end

    assign keyed = subbed ^ rkey_i;

    for (genvar c = 0; c < NB; c++) begin : g_mix
        aes_col_t col_out;
        aes_inv_mixcol u_mixcol (
            .col_i (keyed[c*4 +: 4]),
            .col_o (col_out)
        );
        assign mixed[c*4 +: 4] = col_out;
    end

    assign blk_o = skip_mix_i ? keyed : mixed;
endmodule

// File: rtl/aes_inv_seq.sv
module aes_inv_seq
    import aes_inv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] klen_i,
    output seq_t       seq_o,
    output logic       done_o
);
    phase_e            phase_q;
    logic [RIDX_W-1:0] cnt_q;
    logic [RIDX_W-1:0] nr_sel;

    assign nr_sel = nr_of(klen_e'(klen_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= nr_sel - RIDX_W'(1);
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - RIDX_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        seq_o.load = (phase_q == PH_IDLE) && start_i;
        seq_o.run  = (phase_q == PH_RUN);
        seq_o.last = (phase_q == PH_RUN) && (cnt_q == '0);
        seq_o.idx  = (phase_q == PH_RUN) ? cnt_q : nr_sel;
    end

    // R3: first round after load asks for key Nr-1
    a_r3_first_index: assert property (@(posedge clk) disable iff (rst)
        seq_o.load |=> (seq_o.run && seq_o.idx == nr_of(klen_e'($past(klen_i))) - RIDX_W'(1)));

    // R3: index falls by one each running cycle
    a_r3_index_descends: assert property (@(posedge clk) disable iff (rst)
        (seq_o.run && seq_o.idx != '0) |=> (seq_o.run && seq_o.idx == $past(seq_o.idx) - RIDX_W'(1)));

    // R4: the round using key 0 is followed by done and idle
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        seq_o.last |=> (done_o && !seq_o.run));

    // R4: done lasts a single cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: a start while running does not reload the counter
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (seq_o.run && start_i && seq_o.idx != '0) |=> (seq_o.idx == $past(seq_o.idx) - RIDX_W'(1)));
endmodule

// File: rtl/aes_inv_engine.sv
module aes_inv_engine
    import aes_inv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        klen_i,
    input  logic [BLK_W-1:0]  ct_i,
    output logic [RIDX_W-1:0] rk_idx_o,
    input  logic [BLK_W-1:0]  rk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BLK_W-1:0]  pt_o
);
    seq_t     seq;
    aes_blk_t st_q, rnd_out, pt_q;
    aes_blk_t rkey;

    assign rkey = rk_i;

    aes_inv_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .klen_i  (klen_i),
        .seq_o   (seq),
        .done_o  (done_o)
    );

    aes_inv_round u_round (
        .blk_i      (st_q),
        .rkey_i     (rkey),
        .skip_mix_i (seq.last),
        .blk_o      (rnd_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            pt_q <= '0;
        end else begin
            if (seq.load) begin
                st_q <= ct_i ^ rk_i;
            end else if (seq.run) begin
                st_q <= rnd_out;
            end
            if (seq.last) begin
                pt_q <= rnd_out;
            end
        end
    end

    assign rk_idx_o = seq.idx;
    assign busy_o   = seq.run;
    assign pt_o     = pt_q;

    // R8: plaintext output moves only together with done
    a_r8_pt_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(pt_o));

    // R4: done never coincides with busy
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/test_aes_inv_engine.sv
`timescale 1ns/1ps
module test_aes_inv_engine;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   klen;
    logic [127:0] ct_in;
    logic [3:0]   rk_idx;
    logic [127:0] rk_in;
    logic         busy;
    logic         done;
    logic [127:0] pt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [127:0] rkeys [0:15];
    logic [7:0]   sb    [0:255];

    always #10 clk = ~clk;

    always_comb rk_in = rkeys[rk_idx];

    aes_inv_engine i_aes_inv_engine (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .klen_i   (klen),
        .ct_i     (ct_in),
        .rk_idx_o (rk_idx),
        .rk_i     (rk_in),
        .busy_o   (busy),
        .done_o   (done),
        .pt_o     (pt)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] b);
        return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
    endfunction

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 8'h00) begin
            if (y[0]) r = r ^ x;
            x = xt(x);
            y = y >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            for (int y = 1; y < 256; y++) begin
                if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            end
            sb[x] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
        end
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    task automatic expand(input logic [255:0] key, input int nk);
        logic [31:0] w [0:59];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        int nr = nk + 6;
        for (int i = 0; i < nk; i++) w[i] = key[255 - 32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = xt(rc);
            end else if (nk > 6 && i % nk == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r <= nr; r++) rkeys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] enc(input logic [127:0] pin, input int nr);
        logic [7:0] s [0:15];
        logic [7:0] t [0:15];
        logic [7:0] a0, a1, a2, a3;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) s[i] = pin[127-8*i -: 8] ^ rkeys[0][127-8*i -: 8];
        for (int rd = 1; rd <= nr; rd++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int row = 0; row < 4; row++)
                    s[c*4+row] = t[((c+row)%4)*4+row];
            if (rd < nr) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rkeys[rd][127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    function automatic int nr_code(input logic [1:0] code);
        return (code == 2'd0) ? 10 : (code == 2'd1) ? 12 : 14;
    endfunction

    task automatic run_block(input logic [1:0] code, input logic [127:0] c, input logic [127:0] exp, input bit poke);
        int nr = nr_code(code);
        logic [127:0] prev_pt;
        @(negedge clk);
        klen  = code;
        ct_in = c;
        start = 1'b1;
        #1;
        chk(rk_idx == 4'(nr), "R2 idle index", 128'(rk_idx), 128'(nr));
        @(negedge clk);
        start = 1'b0;
        prev_pt = pt;
        for (int k = 1; k <= nr; k++) begin
            chk(rk_idx == 4'(nr - k), "R3 key index", 128'(rk_idx), 128'(nr - k));
            chk(busy == 1'b1 && done == 1'b0, "R4 busy window", {busy, done}, 128'b10);
            chk(pt == prev_pt, "R8 hold while busy", pt, prev_pt);
            if (poke && k == 2) begin
                start = 1'b1;
                ct_in = ~c;
            end
            if (poke && k == 4) start = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b1 && busy == 1'b0, "R4 done pulse", {busy, done}, 128'b01);
        chk(pt == exp, poke ? "R9 start while busy" : "R6 plaintext", pt, exp);
        @(negedge clk);
        chk(done == 1'b0, "R4 done single", 128'(done), 128'd0);
        chk(pt == exp, "R8 hold after done", pt, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] key;
        logic [127:0] p;
        rst   = 1'b1;
        start = 1'b0;
        klen  = 2'd0;
        ct_in = '0;
        for (int i = 0; i < 16; i++) rkeys[i] = '0;
        build_sbox();
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && pt == '0, "R1 in reset", pt, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && pt == '0, "R1 after reset", pt, 128'd0);

        for (int code = 0; code < 4; code++) begin
            klen = 2'(code);
            #1;
            chk(rk_idx == 4'(nr_code(2'(code))), "R2 code map", 128'(rk_idx), 128'(nr_code(2'(code))));
        end

        // known-answer vectors, byte layout per R7
        expand({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4);
        chk(enc(128'h00112233445566778899aabbccddeeff, 10) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
            "R7 bench model 128", enc(128'h00112233445566778899aabbccddeeff, 10), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_block(2'd0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, 1'b0);
        expand({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 6);
        run_block(2'd1, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, 128'h00112233445566778899aabbccddeeff, 1'b0);
        expand(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 8);
        run_block(2'd2, 128'h8ea2b7ca516745bfeafc49904b496089, 128'h00112233445566778899aabbccddeeff, 1'b0);

        // R5 R6 R9: pattern sweep over every code
        for (int code = 0; code < 4; code++) begin
            int nk = (code == 0) ? 4 : (code == 1) ? 6 : 8;
            key = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            expand(key, nk);
            for (int n = 0; n < 14; n++) begin
                p = (n == 0) ? '0 : (n == 1) ? '1 : {$urandom, $urandom, $urandom, $urandom};
                run_block(2'(code), enc(p, nr_code(2'(code))), p, n == 3);
            end
        end

        // R7: every single-bit plaintext under one 128-bit key
        key = {$urandom, $urandom, $urandom, $urandom, 128'h0};
        expand(key, 4);
        for (int b = 0; b < 128; b++) begin
            p = 128'h1 << b;
            run_block(2'd0, enc(p, 10), p, 1'b0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule